// File: doc/BRIEF.md
# Store Address and Write Unit

This block executes the store instructions of a small 32-bit core. It takes a 32-bit instruction word, pulls out the register indices the register file must read, and receives three operand values: the address base, the value to store and, for register-offset forms, an offset. It decodes word, halfword and byte stores in both the immediate-offset and the register-offset forms and adds the base to the selected offset to form the effective address.

When the access is naturally aligned, the block issues one write beat on a valid/ready request channel. The stored value is copied onto every byte lane and a byte-enable mask marks the lanes that memory must update. Lane numbering is little-endian. The block then waits for the write response. A misaligned address, or a response that reports an error, produces a one-cycle fault pulse for the exception logic. A misaligned store never reaches memory.

The block handles one store at a time. It accepts a new instruction only while no write is outstanding.

Top module: `store_write_unit`

## Requirements
- R1: `decode_ok` is high exactly when `insn[6:0]` is one of these store opcodes: 0x18 word/immediate, 0x19 halfword/immediate, 0x1b byte/immediate, 0x1a halfword/register, 0x1c byte/register, or the parameter `OP_WORD_REG` (default 0x1d) word/register. For any other value it is low.
- R2: In the immediate forms the 15-bit offset is `{insn[31:21], insn[10:7]}`. It is sign-extended, then multiplied by 4 for a word, by 2 for a halfword and by 1 for a byte. The result is added to `base_val`.
- R3: In the register forms the effective address is `base_val + offs_val` (modulo 2^32). Instruction bits [10:7] and [31:26] have no effect.
- R4: `mem_wdata` carries the low byte of `data_val` in all four lanes for a byte store, and the low halfword of `data_val` in both halves for a halfword store. For a word store it carries all of `data_val`.
- R5: `mem_wstrb` bit i enables byte lane i (address offset i). A word store gives 4'b1111. A halfword store gives 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. A byte store gives the one-hot mask `1 << addr[1:0]`.
- R6: A word store whose address has a nonzero value in bits [1:0], or a halfword store whose address has bit 0 set, raises `fault` for exactly the one cycle after it is accepted. No write request is issued for it. Byte stores are never misaligned.
- R7: While `mem_wvalid` is high and `mem_wready` is low, `mem_wvalid`, `mem_waddr`, `mem_wdata` and `mem_wstrb` hold their values.
- R8: A write response (`mem_bvalid`) with `mem_berr` high raises `fault` for the one cycle after the response. A response with `mem_berr` low produces no fault.
- R9: `req_ready` is high only when no write is outstanding. An instruction is accepted when `req_valid` and `req_ready` are both high. An accepted instruction with an unknown opcode produces no write and no fault.
- R10: After reset, `req_ready` is 1 and `mem_wvalid` and `fault` are 0.
- R11: `mem_wvalid` rises in the cycle after a valid aligned store is accepted.
- R12: `rd_base_idx` is `insn[15:11]`, `rd_data_idx` is `insn[20:16]` and `rd_offs_idx` is `insn[25:21]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Instruction present |
| req_ready | output | 1 | Unit idle, able to accept |
| insn | input | 32 | Store instruction word |
| base_val | input | 32 | Value of the address base register |
| data_val | input | 32 | Value of the register to store |
| offs_val | input | 32 | Value of the offset register (register forms) |
| decode_ok | output | 1 | Opcode is a known store |
| rd_base_idx | output | 5 | Register index of the address base |
| rd_data_idx | output | 5 | Register index of the stored value |
| rd_offs_idx | output | 5 | Register index of the offset |
| mem_wvalid | output | 1 | Write request valid |
| mem_wready | input | 1 | Memory accepts the write |
| mem_waddr | output | 32 | Write byte address |
| mem_wdata | output | 32 | Write data, lane-replicated |
| mem_wstrb | output | 4 | Byte enables, bit i is lane i |
| mem_bvalid | input | 1 | Write response present |
| mem_berr | input | 1 | Write response reports an error |
| fault | output | 1 | One-cycle memory fault pulse |

## Verification
Two behaviours are hard to reach from the ports. The first is a held write request, because memory has to withhold ready for several cycles while the request is outstanding. The second is an error response, which only arrives after a write that was itself legal. The bench models memory as a responder that stretches the ready wait and flags the response as an error on chosen transactions, and the scoreboard expects a write followed by a fault for those. The immediate tests use offsets whose bits cross the boundary between the two instruction fields, and the most negative value of each size, so that a mistake in reassembly or scaling shows up in the address.

// File: rtl/store_pkg.sv
package store_pkg;

    localparam int XLEN   = 32;
    localparam int LANES  = XLEN / 8;
    localparam int LOFF_W = $clog2(LANES);
    localparam int IMM_W  = 15;
    localparam int RIDX_W = 5;
    localparam int OPC_W  = 7;

    localparam logic [OPC_W-1:0] OPC_WORD_IMM = 7'h18;
    localparam logic [OPC_W-1:0] OPC_HALF_IMM = 7'h19;
    localparam logic [OPC_W-1:0] OPC_HALF_REG = 7'h1a;
    localparam logic [OPC_W-1:0] OPC_BYTE_IMM = 7'h1b;
    localparam logic [OPC_W-1:0] OPC_BYTE_REG = 7'h1c;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_RESP  = 2'd2
    } wstate_e;

    typedef struct packed {
        logic              ok;
        acc_size_e         size;
        logic              use_reg;
        logic [XLEN-1:0]   imm;
        logic [RIDX_W-1:0] base_idx;
        logic [RIDX_W-1:0] data_idx;
        logic [RIDX_W-1:0] offs_idx;
    } decode_t;

endpackage

// File: rtl/store_decode.sv
module store_decode
    import store_pkg::*;
#(
    parameter logic [OPC_W-1:0] OP_WORD_REG = 7'h1d
) (
    input  logic [XLEN-1:0] insn,
    output decode_t         dec
);

    logic [IMM_W-1:0] raw_imm;
    logic [XLEN-1:0]  sext_imm;

    assign raw_imm  = {insn[31:21], insn[10:7]};
    assign sext_imm = {{(XLEN-IMM_W){raw_imm[IMM_W-1]}}, raw_imm};

    always_comb begin
        dec          = '0;
        dec.base_idx = insn[15:11];
        dec.data_idx = insn[20:16];
        dec.offs_idx = insn[25:21];
        case (insn[OPC_W-1:0])
            OPC_WORD_IMM: begin dec.ok = 1'b1; dec.size = SZ_WORD; dec.use_reg = 1'b0; end
            OPC_HALF_IMM: begin dec.ok = 1'b1; dec.size = SZ_HALF; dec.use_reg = 1'b0; end
            OPC_BYTE_IMM: begin dec.ok = 1'b1; dec.size = SZ_BYTE; dec.use_reg = 1'b0; end
            OPC_HALF_REG: begin dec.ok = 1'b1; dec.size = SZ_HALF; dec.use_reg = 1'b1; end
            OPC_BYTE_REG: begin dec.ok = 1'b1; dec.size = SZ_BYTE; dec.use_reg = 1'b1; end
            OP_WORD_REG:  begin dec.ok = 1'b1; dec.size = SZ_WORD; dec.use_reg = 1'b1; end
            default:      begin dec.ok = 1'b0; dec.size = SZ_BYTE; dec.use_reg = 1'b0; end
        endcase
        // scale the offset by the access size
        case (dec.size)
            SZ_WORD: dec.imm = sext_imm << 2;
            SZ_HALF: dec.imm = sext_imm << 1;
            default: dec.imm = sext_imm;
        endcase
        if (dec.use_reg) begin
            dec.imm = '0;
        end
    end

endmodule

// File: rtl/store_agen.sv
module store_agen
    import store_pkg::*;
(
    input  decode_t         dec,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] offs_val,
    output logic [XLEN-1:0] addr,
    output logic            misaligned
);

    logic [XLEN-1:0] offset;

    assign offset = dec.use_reg ? offs_val : dec.imm;
    assign addr   = base_val + offset;

    always_comb begin
        case (dec.size)
            SZ_WORD: misaligned = (addr[1:0] != 2'b00);
            SZ_HALF: misaligned = addr[0];
            default: misaligned = 1'b0;
        endcase
    end

endmodule

// File: rtl/store_lanes.sv
module store_lanes
    import store_pkg::*;
(
    input  acc_size_e         size,
    input  logic [LOFF_W-1:0] addr_lo,
    input  logic [XLEN-1:0]   data_in,
    output logic [XLEN-1:0]   wdata,
    output logic [LANES-1:0]  wstrb
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wdata[8*i +: 8] = (size == SZ_WORD) ? data_in[8*i +: 8] :
                                 (size == SZ_HALF) ? data_in[8*(i%2) +: 8] :
                                                     data_in[7:0];
        assign wstrb[i] = (size == SZ_WORD) ? 1'b1 :
                          (size == SZ_HALF) ? (addr_lo[1] == 1'(i/2)) :
                                              (addr_lo == LOFF_W'(i));
    end

endmodule

// File: rtl/store_write_unit.sv
module store_write_unit
    import store_pkg::*;
#(
    parameter logic [OPC_W-1:0] OP_WORD_REG = 7'h1d
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [XLEN-1:0]   insn,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   data_val,
    input  logic [XLEN-1:0]   offs_val,
    output logic              decode_ok,
    output logic [RIDX_W-1:0] rd_base_idx,
    output logic [RIDX_W-1:0] rd_data_idx,
    output logic [RIDX_W-1:0] rd_offs_idx,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    output logic [XLEN-1:0]   mem_waddr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic [LANES-1:0]  mem_wstrb,
    input  logic              mem_bvalid,
    input  logic              mem_berr,
    output logic              fault
);

    typedef struct packed {
        wstate_e          st;
        logic [XLEN-1:0]  addr;
        logic [XLEN-1:0]  data;
        logic [LANES-1:0] strb;
        logic             fault;
    } regs_t;

    localparam regs_t REGS_RST = '{st: ST_IDLE, addr: '0, data: '0, strb: '0, fault: 1'b0};

    decode_t          dec;
    logic [XLEN-1:0]  eff_addr;
    logic             misal;
    logic [XLEN-1:0]  lane_data;
    logic [LANES-1:0] lane_strb;
    logic             accept;
    regs_t            r_d, r_q;

    store_decode #(.OP_WORD_REG(OP_WORD_REG)) u_dec (
        .insn (insn),
        .dec  (dec)
    );

    store_agen u_agen (
        .dec        (dec),
        .base_val   (base_val),
        .offs_val   (offs_val),
        .addr       (eff_addr),
        .misaligned (misal)
    );

    store_lanes u_lanes (
        .size    (dec.size),
        .addr_lo (eff_addr[LOFF_W-1:0]),
        .data_in (data_val),
        .wdata   (lane_data),
        .wstrb   (lane_strb)
    );

    assign accept = req_valid && (r_q.st == ST_IDLE);

    always_comb begin
        r_d       = r_q;
        r_d.fault = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (accept && dec.ok) begin
                    if (misal) begin
                        r_d.fault = 1'b1;
                    end else begin
                        r_d.st   = ST_WRITE;
                        r_d.addr = eff_addr;
                        r_d.data = lane_data;
                        r_d.strb = lane_strb;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_wready) begin
                    r_d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                if (mem_bvalid) begin
                    r_d.st    = ST_IDLE;
                    r_d.fault = mem_berr;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == ST_IDLE);
    assign mem_wvalid  = (r_q.st == ST_WRITE);
    assign mem_waddr   = r_q.addr;
    assign mem_wdata   = r_q.data;
    assign mem_wstrb   = r_q.strb;
    assign fault       = r_q.fault;
    assign decode_ok   = dec.ok;
    assign rd_base_idx = dec.base_idx;
    assign rd_data_idx = dec.data_idx;
    assign rd_offs_idx = dec.offs_idx;

endmodule

// File: rtl/store_write_unit_chk.sv
module store_write_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_wvalid,
    input logic        mem_wready,
    input logic [31:0] mem_waddr,
    input logic [31:0] mem_wdata,
    input logic [3:0]  mem_wstrb,
    input logic        fault
);

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_waddr)
                                      && $stable(mem_wdata) && $stable(mem_wstrb));

    a_r5_strb_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> ($countones(mem_wstrb) == 1 || mem_wstrb == 4'b0011
                        || mem_wstrb == 4'b1100 || mem_wstrb == 4'b1111));

    a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid && mem_wstrb == 4'b1111 |-> mem_waddr[1:0] == 2'b00);

    a_r6_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid && $countones(mem_wstrb) == 2 |-> mem_waddr[0] == 1'b0);

    a_r9_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && mem_wvalid));

    a_r11_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wvalid) |-> $past(req_valid && req_ready));

    a_r6_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !mem_wvalid);

endmodule

bind store_write_unit store_write_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .mem_wvalid (mem_wvalid),
    .mem_wready (mem_wready),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_wstrb  (mem_wstrb),
    .fault      (fault)
);

// File: tb/sim_store_write_unit.sv
`timescale 1ns/1ps
module sim_store_write_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] insn = '0;
    logic [31:0] base_val = '0;
    logic [31:0] data_val = '0;
    logic [31:0] offs_val = '0;
    logic        decode_ok;
    logic [4:0]  rd_base_idx, rd_data_idx, rd_offs_idx;
    logic        mem_wvalid;
    logic        mem_wready = 1'b0;
    logic [31:0] mem_waddr, mem_wdata;
    logic [3:0]  mem_wstrb;
    logic        mem_bvalid = 1'b0;
    logic        mem_berr = 1'b0;
    logic        fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_fault;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        string       tag;
    } exp_t;

    exp_t sbq[$];

    always #4 clk = ~clk;

    store_write_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .insn(insn), .base_val(base_val), .data_val(data_val), .offs_val(offs_val),
        .decode_ok(decode_ok), .rd_base_idx(rd_base_idx), .rd_data_idx(rd_data_idx),
        .rd_offs_idx(rd_offs_idx), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_bvalid(mem_bvalid), .mem_berr(mem_berr), .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_i(input logic [6:0] op, input logic [14:0] imm,
                                         input logic [4:0] b, input logic [4:0] d);
        return {imm[14:4], d, b, imm[3:0], op};
    endfunction

    function automatic logic [31:0] mk_r(input logic [6:0] op, input logic [4:0] b,
                                         input logic [4:0] d, input logic [4:0] o,
                                         input logic [3:0] j4, input logic [5:0] j6);
        return {j6, o, d, b, j4, op};
    endfunction

    task automatic issue(input logic [31:0] ins, input logic [31:0] b, input logic [31:0] d,
                         input logic [31:0] o, input bit exp_ok, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        insn = ins; base_val = b; data_val = d; offs_val = o; req_valid = 1'b1;
        #1 chk(decode_ok == exp_ok, "R1", {tag, " decode_ok"}, 32'(decode_ok), 32'(exp_ok));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // aligned store: write expected, then response
    task automatic do_write(input logic [31:0] ins, input logic [31:0] b, input logic [31:0] d,
                            input logic [31:0] o, input logic [31:0] ea, input logic [31:0] ed,
                            input logic [3:0] es, input int stall, input bit err,
                            input string tag);
        exp_t e;
        e.is_fault = 1'b0; e.addr = ea; e.data = ed; e.strb = es; e.tag = tag;
        sbq.push_back(e);
        if (err) begin
            e.is_fault = 1'b1; e.tag = {tag, " R8 error response"};
            sbq.push_back(e);
        end
        issue(ins, b, d, o, 1'b1, tag);
        #2 chk(mem_wvalid == 1'b1, "R11", {tag, " wvalid after accept"}, 32'(mem_wvalid), 32'd1);
        repeat (stall + 1) @(negedge clk);
        mem_wready = 1'b1;
        @(negedge clk);
        mem_wready = 1'b0; mem_bvalid = 1'b1; mem_berr = err;
        @(negedge clk);
        mem_bvalid = 1'b0; mem_berr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // misaligned store: fault expected, no write
    task automatic do_misal(input logic [31:0] ins, input logic [31:0] b, input logic [31:0] o,
                            input string tag);
        exp_t e;
        e.is_fault = 1'b1; e.addr = '0; e.data = '0; e.strb = '0; e.tag = tag;
        sbq.push_back(e);
        issue(ins, b, 32'h0, o, 1'b1, tag);
        #2 chk(mem_wvalid == 1'b0, "R6", {tag, " no write"}, 32'(mem_wvalid), 32'd0);
        repeat (3) @(negedge clk);
    endtask

    // monitor / scoreboard
    logic        hold_v = 1'b0;
    logic [31:0] h_addr, h_data;
    logic [3:0]  h_strb;
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (hold_v && mem_wvalid) begin
                    chk(mem_waddr == h_addr && mem_wdata == h_data && mem_wstrb == h_strb,
                        "R7", "held request changed", mem_waddr, h_addr);
                end
                hold_v = mem_wvalid && !mem_wready;
                h_addr = mem_waddr; h_data = mem_wdata; h_strb = mem_wstrb;
                if (mem_wvalid && mem_wready) begin
                    if (sbq.size() == 0 || sbq[0].is_fault) begin
                        chk(1'b0, "R9", "unexpected write", mem_waddr, 32'h0);
                        if (sbq.size() != 0) void'(sbq.pop_front());
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        chk(mem_waddr == e.addr, "R2/R3", {e.tag, " addr"}, mem_waddr, e.addr);
                        chk(mem_wdata == e.data, "R4", {e.tag, " data"}, mem_wdata, e.data);
                        chk(mem_wstrb == e.strb, "R5", {e.tag, " strb"}, 32'(mem_wstrb), 32'(e.strb));
                    end
                end
                if (fault) begin
                    if (sbq.size() == 0 || !sbq[0].is_fault) begin
                        chk(1'b0, "R8", "unexpected fault", 32'(fault), 32'd0);
                        if (sbq.size() != 0) void'(sbq.pop_front());
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        chk(1'b1, "R6", {e.tag, " fault"}, 32'(fault), 32'd1);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R10 reset state
        chk(req_ready == 1'b1, "R10", "req_ready", 32'(req_ready), 32'd1);
        chk(mem_wvalid == 1'b0, "R10", "wvalid", 32'(mem_wvalid), 32'd0);
        chk(fault == 1'b0, "R10", "fault", 32'(fault), 32'd0);

        // R12 index extraction
        insn = mk_r(7'h1c, 5'd7, 5'd19, 5'd26, 4'h0, 6'h0);
        #1;
        chk(rd_base_idx == 5'd7,  "R12", "base idx", 32'(rd_base_idx), 32'd7);
        chk(rd_data_idx == 5'd19, "R12", "data idx", 32'(rd_data_idx), 32'd19);
        chk(rd_offs_idx == 5'd26, "R12", "offs idx", 32'(rd_offs_idx), 32'd26);

        // R2 immediate forms
        do_write(mk_i(7'h18, 15'h0002, 5'd1, 5'd2), 32'h1000, 32'hA1B2C3D4, 32'h0,
                 32'h1008, 32'hA1B2C3D4, 4'b1111, 0, 1'b0, "R2 word imm +8");
        do_write(mk_i(7'h18, 15'h7fff, 5'd1, 5'd2), 32'h2000, 32'h0BADF00D, 32'h0,
                 32'h1FFC, 32'h0BADF00D, 4'b1111, 1, 1'b0, "R2 word imm -4");
        do_write(mk_i(7'h18, 15'h0123, 5'd3, 5'd4), 32'h10000, 32'h55AA55AA, 32'h0,
                 32'h1048C, 32'h55AA55AA, 4'b1111, 0, 1'b0, "R2 word imm split fields");
        do_write(mk_i(7'h19, 15'h0003, 5'd3, 5'd4), 32'h100, 32'h1234BEEF, 32'h0,
                 32'h106, 32'hBEEFBEEF, 4'b1100, 0, 1'b0, "R2 half imm upper lane");
        do_write(mk_i(7'h19, 15'h4000, 5'd3, 5'd4), 32'h10000, 32'h0000CAFE, 32'h0,
                 32'h8000, 32'hCAFECAFE, 4'b0011, 0, 1'b0, "R2 half imm min");
        do_write(mk_i(7'h1b, 15'h3fff, 5'd5, 5'd6), 32'h0, 32'h7777775A, 32'h0,
                 32'h3FFF, 32'h5A5A5A5A, 4'b1000, 0, 1'b0, "R2 byte imm max");
        do_write(mk_i(7'h1b, 15'h4000, 5'd5, 5'd6), 32'h5001, 32'h00000011, 32'h0,
                 32'h1001, 32'h11111111, 4'b0010, 0, 1'b0, "R2 byte imm min");

        // R3 register forms, junk in unused fields
        do_write(mk_r(7'h1a, 5'd1, 5'd2, 5'd3, 4'hF, 6'h3F), 32'h300, 32'hAAAA5555, 32'h2,
                 32'h302, 32'h55555555, 4'b1100, 0, 1'b0, "R3 half reg junk fields");
        do_write(mk_r(7'h1c, 5'd1, 5'd2, 5'd3, 4'hA, 6'h15), 32'h400, 32'h000000C3, 32'hFFFFFFFF,
                 32'h3FF, 32'hC3C3C3C3, 4'b1000, 0, 1'b0, "R3 byte reg negative");
        do_write(mk_r(7'h1d, 5'd1, 5'd2, 5'd3, 4'h0, 6'h0), 32'h800, 32'hDEADBEEF, 32'h10,
                 32'h810, 32'hDEADBEEF, 4'b1111, 3, 1'b0, "R7 word reg stalled");

        // R8 error response
        do_write(mk_i(7'h18, 15'h0000, 5'd1, 5'd2), 32'h40, 32'h01020304, 32'h0,
                 32'h40, 32'h01020304, 4'b1111, 2, 1'b1, "R8 word with error");

        // R6 misaligned
        do_misal(mk_i(7'h18, 15'h0000, 5'd1, 5'd2), 32'h1002, 32'h0, "R6 word misaligned");
        do_misal(mk_i(7'h19, 15'h0000, 5'd1, 5'd2), 32'h1001, 32'h0, "R6 half misaligned");
        do_misal(mk_r(7'h1d, 5'd1, 5'd2, 5'd3, 4'h0, 6'h0), 32'h800, 32'h1, "R6 word reg misaligned");

        // R9 unknown opcodes: no write, no fault
        issue(32'h00000020, 32'h100, 32'h1, 32'h0, 1'b0, "R9 opcode 0x20");
        repeat (4) @(negedge clk);
        #2 chk(req_ready && !mem_wvalid && !fault, "R9", "idle after unknown opcode",
               32'(mem_wvalid), 32'd0);
        issue(32'h00000000, 32'h100, 32'h1, 32'h0, 1'b0, "R9 opcode 0x00");
        repeat (4) @(negedge clk);
        #2 chk(req_ready && !mem_wvalid && !fault, "R9", "idle after zero opcode",
               32'(mem_wvalid), 32'd0);

        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R9", "scoreboard drained", 32'(sbq.size()), 32'd0);
        finish_run();
    end

endmodule